// File: doc/BRIEF.md
# Stack Frame Release Sequencer

This block carries out one multi-register restore for a 32-bit processor that has 32 general registers. It takes a two-halfword instruction word and the current stack pointer. It first releases the local frame by adding a scaled 5-bit size to the stack pointer. It then pops one stack word into each register picked by a 12-bit select list. In the jump form it finishes by loading the program counter from a named register.

The block drives a word-read memory port with combinational return data, and a register-file write port. It also uses one register-file read port to fetch the jump target. On the final cycle of each operation it raises a one-cycle `done` together with the final stack pointer, so the surrounding core can write the stack pointer back. Instruction fetch and hazard interlocks belong to the surrounding core.

Top module: `frame_release_seq`

## Requirements
- R1: After reset and whenever no operation is running, `busy`, `done`, `memRdEn`, `rfWe` and `pcWe` are all 0.
- R2: A `start` is accepted only when `instrHi[15:6]` equals 10'b0000011001. With any other value, nothing starts and no port strobe is raised.
- R3: The first cycle after acceptance only adjusts the stack pointer, by `spIn + (instrHi[5:1] << 2)`. The first pop reads from that address.
- R4: The select list is `{instrHi[0], instrLo[15:5]}`, and list bit k selects register 20+k. Selected registers are popped in ascending order, one per cycle. Each pop reads the word at the current stack pointer, writes it to the register and then adds 4 to the stack pointer.
- R5: When `instrLo[4:0]` is 0 (plain form), `busy` lasts N+1 cycles, where N is the number of selected registers.
- R6: When `instrLo[4:0]` is nonzero (jump form), `busy` lasts N+3 cycles. On the last cycle `pcWe` is raised and `pcData` holds the named register's value after all pops.
- R7: An empty list performs only the adjustment (1 cycle), plus the jump when present (3 cycles).
- R8: `done` and `spWe` are high for exactly the last busy cycle. `spData` is then `spIn + 4*imm + 4*N`.
- R9: A `start` raised while an operation is running is ignored and does not disturb that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to accept the instruction on `instrHi`/`instrLo` |
| instrHi | input | 16 | First instruction halfword |
| instrLo | input | 16 | Second instruction halfword |
| spIn | input | 32 | Stack pointer at start |
| busy | output | 1 | An operation is running |
| done | output | 1 | Last cycle of the operation |
| memRdEn | output | 1 | Word read strobe |
| memAddr | output | 32 | Word read address |
| memRdData | input | 32 | Read data, same cycle |
| rfWe | output | 1 | Register write strobe |
| rfAddr | output | 5 | Register write index |
| rfData | output | 32 | Register write data |
| rfRdAddr | output | 5 | Register read index for the jump target |
| rfRdData | input | 32 | Register read data |
| pcWe | output | 1 | Program counter load strobe |
| pcData | output | 32 | New program counter |
| spWe | output | 1 | Stack pointer write-back strobe |
| spData | output | 32 | Final stack pointer |

## Verification
The hardest case to reach is the jump form in which the named register is also in the pop list. The target must then be the value popped into it, not the stale one, so the read has to follow the final write by a cycle. The bench names r31 as the jump register and selects r31 in the list. The memory returns address-derived words, which makes a stale read visible on `pcData`. A second hard case is a `start` pulse raised in mid-sequence, which the bench injects on the third busy cycle of a running operation.

// File: rtl/frame_release_pkg.sv
package frame_release_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADJ, ST_POP, ST_JRD, ST_JMP
  } seqState_t;

  typedef struct packed {
    logic load;        // capture operands
    logic adj;         // add frame size to stack pointer
    logic pop;         // read one word, write register, step stack pointer
    logic grabTarget;  // capture jump target from register file
    logic jump;        // drive program counter
    logic fin;         // final cycle of the operation
  } dpStrobe_t;
endpackage

// File: rtl/frame_release_ctrl.sv
module frame_release_ctrl
  import frame_release_pkg::*;
#(
  parameter int LIST_W = 12,
  parameter int REG_BASE = 20,
  parameter int RAW = 5,
  parameter logic [9:0] OPCODE = 10'b0000011001
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [9:0]     opField,
  input  logic           listTop,
  input  logic [15:0]    instrLo,
  output dpStrobe_t      strobe,
  output logic [RAW-1:0] popReg,
  output logic [RAW-1:0] jumpReg,
  output logic           busy
);
  localparam int IDX_W = $clog2(LIST_W);

  seqState_t state, stateNext;
  logic [LIST_W-1:0] pending;
  logic [LIST_W-1:0] pendingLeft;
  logic [IDX_W-1:0]  idx;
  logic              found;
  logic              opOk;

  assign opOk = (opField == OPCODE);
  assign pendingLeft = pending & (pending - LIST_W'(1));

  always_comb begin
    idx = '0;
    found = 1'b0;
    for (int i = 0; i < LIST_W; i++) begin
      if (!found && pending[i]) begin
        idx = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  assign popReg = RAW'(REG_BASE) + RAW'(idx);
  assign busy = (state != ST_IDLE);

  always_comb begin
    strobe = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start && opOk) begin
        strobe.load = 1'b1;
        stateNext = ST_ADJ;
      end
      ST_ADJ: begin
        strobe.adj = 1'b1;
        if (pending != '0) stateNext = ST_POP;
        else if (jumpReg != '0) stateNext = ST_JRD;
        else begin
          strobe.fin = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      ST_POP: begin
        strobe.pop = 1'b1;
        if (pendingLeft == '0) begin
          if (jumpReg != '0) stateNext = ST_JRD;
          else begin
            strobe.fin = 1'b1;
            stateNext = ST_IDLE;
          end
        end
      end
      ST_JRD: begin
        strobe.grabTarget = 1'b1;
        stateNext = ST_JMP;
      end
      ST_JMP: begin
        strobe.jump = 1'b1;
        strobe.fin = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pending <= '0;
      jumpReg <= '0;
    end else begin
      state <= stateNext;
      if (strobe.load) begin
        pending <= {listTop, instrLo[15:5]};
        jumpReg <= instrLo[4:0];
      end else if (strobe.pop) begin
        pending <= pendingLeft;
      end
    end
  end
endmodule

// File: rtl/frame_release_dp.sv
module frame_release_dp
  import frame_release_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAME_W = 5,
  parameter int RAW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [FRAME_W-1:0] frameIn,
  input  logic [DATA_W-1:0] spIn,
  input  logic [RAW-1:0]    popReg,
  input  logic [RAW-1:0]    jumpReg,
  output logic              memRdEn,
  output logic [DATA_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              rfWe,
  output logic [RAW-1:0]    rfAddr,
  output logic [DATA_W-1:0] rfData,
  output logic [RAW-1:0]    rfRdAddr,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              pcWe,
  output logic [DATA_W-1:0] pcData,
  output logic              spWe,
  output logic [DATA_W-1:0] spData
);
  localparam int PAD_W = DATA_W - FRAME_W - 2;

  logic [DATA_W-1:0]  spReg, spNext, target;
  logic [FRAME_W-1:0] frameReg;

  always_comb begin
    spNext = spReg;
    if (strobe.adj) spNext = spReg + {{PAD_W{1'b0}}, frameReg, 2'b00};
    else if (strobe.pop) spNext = spReg + DATA_W'(4);
  end

  assign memRdEn  = strobe.pop;
  assign memAddr  = spReg;
  assign rfWe     = strobe.pop;
  assign rfAddr   = popReg;
  assign rfData   = memRdData;
  assign rfRdAddr = jumpReg;
  assign pcWe     = strobe.jump;
  assign pcData   = target;
  assign spWe     = strobe.fin;
  assign spData   = spNext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spReg <= '0;
      frameReg <= '0;
      target <= '0;
    end else begin
      if (strobe.load) begin
        spReg <= spIn;
        frameReg <= frameIn;
      end else begin
        spReg <= spNext;
      end
      if (strobe.grabTarget) target <= rfRdData;
    end
  end
endmodule

// File: rtl/frame_release_seq.sv
module frame_release_seq
  import frame_release_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LIST_W = 12,
  parameter int REG_BASE = 20,
  parameter int RAW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       instrHi,
  input  logic [15:0]       instrLo,
  input  logic [DATA_W-1:0] spIn,
  output logic              busy,
  output logic              done,
  output logic              memRdEn,
  output logic [DATA_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              rfWe,
  output logic [RAW-1:0]    rfAddr,
  output logic [DATA_W-1:0] rfData,
  output logic [RAW-1:0]    rfRdAddr,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              pcWe,
  output logic [DATA_W-1:0] pcData,
  output logic              spWe,
  output logic [DATA_W-1:0] spData
);
  dpStrobe_t strobe;
  logic [RAW-1:0] popReg, jumpReg;

  frame_release_ctrl #(.LIST_W(LIST_W), .REG_BASE(REG_BASE), .RAW(RAW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .opField(instrHi[15:6]), .listTop(instrHi[0]), .instrLo(instrLo),
    .strobe(strobe), .popReg(popReg), .jumpReg(jumpReg), .busy(busy)
  );

  frame_release_dp #(.DATA_W(DATA_W), .FRAME_W(5), .RAW(RAW)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .frameIn(instrHi[5:1]),
    .spIn(spIn), .popReg(popReg), .jumpReg(jumpReg),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .rfWe(rfWe), .rfAddr(rfAddr), .rfData(rfData),
    .rfRdAddr(rfRdAddr), .rfRdData(rfRdData),
    .pcWe(pcWe), .pcData(pcData), .spWe(spWe), .spData(spData)
  );

  assign done = strobe.fin;
endmodule

// File: rtl/frame_release_seq_chk.sv
module frame_release_seq_chk #(
  parameter int DATA_W = 32,
  parameter int RAW = 5,
  parameter int REG_BASE = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              memRdEn,
  input logic [DATA_W-1:0] memAddr,
  input logic              rfWe,
  input logic [RAW-1:0]    rfAddr,
  input logic              pcWe
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(rfWe || pcWe || memRdEn || done)); // R1
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (memRdEn && $past(memRdEn)) |-> (memAddr == $past(memAddr) + DATA_W'(4))); // R4
  AST_POP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rfWe |-> (rfAddr >= RAW'(REG_BASE))); // R4
  AST_JUMP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    pcWe |-> done); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
endmodule

bind frame_release_seq frame_release_seq_chk #(.DATA_W(DATA_W), .RAW(RAW), .REG_BASE(REG_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .memRdEn(memRdEn),
  .memAddr(memAddr), .rfWe(rfWe), .rfAddr(rfAddr), .pcWe(pcWe)
);

// File: tb/frame_release_seq_test.sv
`timescale 1ns/1ps
module frame_release_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] instrHi = '0, instrLo = '0;
  logic [31:0] spIn = '0;
  logic busy, done, memRdEn, rfWe, pcWe, spWe;
  logic [31:0] memAddr, memRdData, rfData, rfRdData, pcData, spData;
  logic [4:0] rfAddr, rfRdAddr;
  logic [31:0] rf [32];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  frame_release_seq uut (.*);

  assign memRdData = {16'hC0DE, memAddr[15:0]};
  assign rfRdData = rf[rfRdAddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= 32'h100 + i;
    end else if (rfWe) begin
      rf[rfAddr] <= rfData;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] hiWord(input logic [4:0] imm, input logic [11:0] lst);
    return {10'b0000011001, imm, lst[11]};
  endfunction

  task automatic runOp(input logic [4:0] imm, input logic [11:0] lst,
                       input logic [4:0] jreg, input logic [31:0] sp0,
                       input bit pokeMid, input string req);
    logic [31:0] expRf [32];
    logic [31:0] sp, spGot, pcGot, firstAddr;
    int n, cycles, doneCnt, pcCnt;
    bit addrSeen, rfOk;
    @(negedge clk);
    instrHi = hiWord(imm, lst);
    instrLo = {lst[10:0], jreg};
    spIn = sp0;
    start = 1'b1;
    for (int i = 0; i < 32; i++) expRf[i] = rf[i];
    @(negedge clk);
    start = 1'b0;
    sp = sp0 + {25'd0, imm, 2'b00};
    n = 0;
    for (int k = 0; k < 12; k++) begin
      if (lst[k]) begin
        expRf[20 + k] = {16'hC0DE, sp[15:0]};
        sp = sp + 4;
        n++;
      end
    end
    cycles = 0; doneCnt = 0; pcCnt = 0; addrSeen = 0;
    spGot = '0; pcGot = '0; firstAddr = '0;
    while (busy && cycles < 64) begin
      cycles++;
      if (memRdEn && !addrSeen) begin addrSeen = 1; firstAddr = memAddr; end
      if (done) begin doneCnt++; spGot = spData; end
      if (done && !spWe) doneCnt = 99;
      if (pcWe) begin pcCnt++; pcGot = pcData; end
      if (pokeMid && cycles == 2) begin
        instrHi = hiWord(5'd3, 12'hFFF);
        instrLo = {11'h7FF, 5'd7};
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(cycles == n + 1 + (jreg != 0 ? 2 : 0), req, "busy cycles", cycles,
          n + 1 + (jreg != 0 ? 2 : 0));
    check(doneCnt == 1, "R8", "done/spWe pulses", doneCnt, 1);
    check(spGot == sp, "R8", "final sp", spGot, sp);
    if (n > 0) check(firstAddr == sp0 + {25'd0, imm, 2'b00}, "R3", "first pop address",
                     firstAddr, sp0 + {25'd0, imm, 2'b00});
    rfOk = 1;
    for (int i = 0; i < 32; i++) if (rf[i] !== expRf[i]) rfOk = 0;
    check(rfOk, "R4", "register file contents", rf[31], expRf[31]);
    if (jreg != 0) begin
      check(pcCnt == 1 && pcGot == expRf[jreg], "R6", "jump target", pcGot, expRf[jreg]);
    end else begin
      check(pcCnt == 0, "R5", "no pc load in plain form", pcCnt, 0);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!busy && !done && !memRdEn && !rfWe && !pcWe, "R1", "idle outputs after reset",
          {busy, done, memRdEn, rfWe, pcWe}, 0);
  endtask

  task automatic testBadOpcode();
    bit quiet = 1;
    @(negedge clk);
    instrHi = {10'b0000011011, 5'd4, 1'b1};
    instrLo = {11'h7FF, 5'd3};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (busy || rfWe || pcWe || memRdEn || spWe) quiet = 0;
      @(negedge clk);
    end
    check(quiet, "R2", "wrong opcode ignored", quiet, 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();                                         // R1
    runOp(5'd5, 12'b0000_0010_0101, 5'd0, 32'h1000, 0, "R5");
    runOp(5'd0, 12'hFFF, 5'd0, 32'h2000, 0, "R5");
    runOp(5'd31, 12'h000, 5'd0, 32'h3000, 0, "R7");       // adjust only
    runOp(5'd2, 12'b1000_0000_0011, 5'd5, 32'h4000, 0, "R6");
    runOp(5'd1, 12'b1000_0000_0100, 5'd31, 32'h5000, 0, "R6"); // target popped
    runOp(5'd7, 12'h000, 5'd9, 32'h6000, 0, "R7");        // jump only
    testBadOpcode();                                      // R2
    runOp(5'd4, 12'b0101_0101_0101, 5'd0, 32'h7000, 1, "R9");
    testReset();                                          // R1 idle after runs
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule